// File: doc/BRIEF.md
# ADC Scan Sequencer Controller

This block runs a multiplexed analog-to-digital converter through a scan of up to eight sample slots. Each slot carries its own input pin selection. A scan converts its slots either one per conversion (sequential) or two per conversion (simultaneous), where conversion k serves slot k and slot k+4. The converter itself sits outside the block. The block tells it which pins to sample and when a conversion starts. When a conversion completes, the block captures the returned data straight into the result register of that slot.

A 3-bit mode field picks how scans start. In once mode, one scan runs per arming write. In triggered mode, every start event while idle begins a scan. In loop mode, scans repeat back to back with no trigger. A start event comes from a software start input, a timer sync input, or a PWM reload. The PWM reload reaches the sync path through a programmable delay. A STOP level blocks new scans. A start event that arrives during a scan sets a sticky overrun bit. Each scan ends by setting an end-of-scan flag and, outside loop mode, an optional one-cycle interrupt pulse.

The block clock runs at twice the converter clock, so one cycle is half a converter clock. Timing follows a pipelined converter. The first conversion after an idle start takes 8.5 converter clocks, and each later conversion in the same run takes 6 converter clocks.

Top module: `scan_seq_ctrl`

## Requirements
- R1: After reset the following outputs are 0: `conv_busy`, `conv_strobe`, `eos_flag`, `scan_irq`, `overrun`, `cfg_err` and all result slots. The configuration is once-sequential, length 1, interrupt disabled, and the block is not armed.
- R2: Mode bits [2:1] select the start behaviour: 00 once, 01 loop, 10 triggered, 11 illegal. Bit 0 = 1 selects simultaneous. `cfg_err` is high for the illegal code, and also in simultaneous mode when a pair in use has the same pin selection on both sides. No scan starts while `cfg_err` is high.
- R3: In sequential mode a scan makes L conversions, where L is the length field (0 is taken as 1, values above 8 are taken as 8). Conversion i drives the pin of slot i on `conv_sel_a` and stores `conv_data_a` into slot i. Slot s holds its 3-bit pin selection at bits [3s+2:3s] of `cfg_sel` and its result at bits [12s+11:12s] of `result`.
- R4: In simultaneous mode a scan makes (L+1)/2 conversions. Conversion k drives slot k on `conv_sel_a` and slot k+4 on `conv_sel_b`, holds `conv_pair` high, and stores `conv_data_a` into slot k and `conv_data_b` into slot k+4.
- R5: A scan started from idle completes its first conversion 17 cycles after the start is accepted, and each further conversion 12 cycles after the previous one. `eos_flag` is set at the last completion. `conv_strobe` is a one-cycle pulse at the start of every conversion.
- R6: Once mode is armed by a configuration write and runs one scan on the next start event. Later start events do nothing, and do not set overrun, until the next configuration write.
- R7: In triggered mode every start event that arrives while idle begins a scan, and that scan pays the full 17-cycle first conversion again.
- R8: In loop mode scans begin after the arming write with no start event and follow each other back to back. Each scan after the first takes 12 cycles per conversion. `eos_flag` is set for each scan, and `scan_irq` is never raised.
- R9: While `sw_stop` is high no new scan starts, including the next loop scan. A scan already running completes.
- R10: A start event is `sw_start`, `timer_sync`, or a delayed PWM reload. A PWM reload sampled at edge E is accepted as a start at edge E + `pwm_delay` + 2.
- R11: A start event during a scan does not restart it and sets `overrun`. `overrun` stays set until a configuration write clears it.
- R12: At the end of a scan in once or triggered mode with the interrupt enabled, `scan_irq` pulses for one cycle together with the setting of `eos_flag`. `eos_flag` stays set until `eos_ack` clears it.
- R13: Result registers have no second buffer. A later scan overwrites the slots it converts and leaves the other slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe; arms the block and clears overrun |
| cfg_mode | input | 3 | Scan mode code |
| cfg_len | input | 4 | Scan length in slots |
| cfg_irq_en | input | 1 | End-of-scan interrupt enable |
| cfg_sel | input | 24 | Pin selection, 3 bits per slot |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Stop level |
| timer_sync | input | 1 | Timer sync pulse |
| pwm_reload | input | 1 | PWM reload event |
| pwm_delay | input | 8 | Delay in cycles applied to the PWM reload |
| eos_ack | input | 1 | Clears the end-of-scan flag |
| conv_strobe | output | 1 | Conversion start pulse |
| conv_busy | output | 1 | Scan in progress |
| conv_pair | output | 1 | Current conversion samples two pins |
| conv_sel_a | output | 3 | Pin for the first side |
| conv_sel_b | output | 3 | Pin for the second side (0 when sequential) |
| conv_data_a | input | 12 | Converter data, first side |
| conv_data_b | input | 12 | Converter data, second side |
| result | output | 96 | Result registers, 12 bits per slot |
| eos_flag | output | 1 | Sticky end-of-scan flag |
| scan_irq | output | 1 | End-of-scan interrupt pulse |
| overrun | output | 1 | Sticky overrun bit |
| cfg_err | output | 1 | Illegal mode or clashing pair |

## Verification
The converter stub returns the pin number plus a base value that the bench changes between scans. A result in the wrong slot or a stale result therefore shows up as a wrong value.

Sequential scans of lengths 0, 3 and 15 separate correct length clamping from an off-by-one conversion count. Simultaneous scans of lengths 8 and 3 show that the pairing is correct and that slots outside the used pairs are left alone.

Start events come from the software input, the timer input, and the PWM reload with delays 0 and 5, in once, triggered and loop modes. These runs separate the timing with the 17-cycle fill from back-to-back 12-cycle conversions, and accepted starts from ignored starts.

Pin clashes are tried both in a pair that is used and in a pair that is not, which checks that the error test depends on the scan length.

// File: rtl/scan_seq_pkg.sv
`timescale 1ns/1ps
package scan_seq_pkg;

    typedef enum logic [1:0] {
        KIND_ONCE = 2'b00,
        KIND_LOOP = 2'b01,
        KIND_TRIG = 2'b10,
        KIND_BAD  = 2'b11
    } start_kind_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic start_kind_e decode_kind(input logic [2:0] mode);
        return start_kind_e'(mode[2:1]);
    endfunction

endpackage

// File: rtl/scan_cfg.sv
`timescale 1ns/1ps
module scan_cfg
    import scan_seq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int SEL_W = 3,
    parameter int LEN_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [2:0]              mode_in,
    input  logic [LEN_W-1:0]        len_in,
    input  logic                    irq_en_in,
    input  logic [SLOTS*SEL_W-1:0]  sel_in,
    output start_kind_e             kind,
    output logic                    simul,
    output logic [LEN_W-1:0]        nconv,
    output logic                    irq_en,
    output logic                    cfg_err,
    output logic [SLOTS*SEL_W-1:0]  sel_flat
);

    localparam int HALF = SLOTS / 2;

    typedef struct packed {
        logic [2:0]             mode;
        logic [LEN_W-1:0]       len;
        logic                   irq_en;
        logic [SLOTS*SEL_W-1:0] sel;
    } cfg_t;

    localparam cfg_t CFG_RST = '{mode: 3'b000, len: LEN_W'(1), irq_en: 1'b0, sel: '0};

    cfg_t cfg_d, cfg_q;
    logic [LEN_W-1:0] npairs;
    logic [HALF-1:0]  clash;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.mode   = mode_in;
            cfg_d.irq_en = irq_en_in;
            cfg_d.sel    = sel_in;
            if (len_in == '0)
                cfg_d.len = LEN_W'(1);
            else if (len_in > LEN_W'(SLOTS))
                cfg_d.len = LEN_W'(SLOTS);
            else
                cfg_d.len = len_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign kind     = decode_kind(cfg_q.mode);
    assign simul    = cfg_q.mode[0];
    assign irq_en   = cfg_q.irq_en;
    assign sel_flat = cfg_q.sel;
    assign npairs   = (cfg_q.len + LEN_W'(1)) >> 1;
    assign nconv    = simul ? npairs : cfg_q.len;

    // a pair only matters if the scan length reaches it
    for (genvar k = 0; k < HALF; k++) begin : g_pair
        assign clash[k] = simul && (LEN_W'(k) < npairs) &&
                          (cfg_q.sel[k*SEL_W +: SEL_W] == cfg_q.sel[(k+HALF)*SEL_W +: SEL_W]);
    end

    assign cfg_err = (kind == KIND_BAD) || (|clash);

endmodule

// File: rtl/scan_sync_delay.sv
`timescale 1ns/1ps
module scan_sync_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [DLY_W-1:0] delay,
    output logic             pulse
);

    typedef struct packed {
        logic             active;
        logic [DLY_W-1:0] cnt;
        logic             pulse;
    } dly_t;

    dly_t dly_d, dly_q;

    always_comb begin
        dly_d       = dly_q;
        dly_d.pulse = 1'b0;
        if (dly_q.active) begin
            if (dly_q.cnt == '0) begin
                dly_d.pulse  = 1'b1;
                dly_d.active = 1'b0;
            end else begin
                dly_d.cnt = dly_q.cnt - DLY_W'(1);
            end
        end
        if (reload) begin
            dly_d.active = 1'b1;
            dly_d.cnt    = delay;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= dly_d;
    end

    assign pulse = dly_q.pulse;

endmodule

// File: rtl/scan_results.sv
`timescale 1ns/1ps
module scan_results #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          idx,
    input  logic                      simul,
    input  logic [DATA_W-1:0]         data_a,
    input  logic [DATA_W-1:0]         data_b,
    output logic [SLOTS*DATA_W-1:0]   res_flat
);

    localparam int HALF = SLOTS / 2;

    logic [DATA_W-1:0] res_d [SLOTS];
    logic [DATA_W-1:0] res_q [SLOTS];

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            res_d[s] = res_q[s];
            if (wr_en) begin
                if (!simul) begin
                    if (idx == IDX_W'(s)) res_d[s] = data_a;
                end else if (s < HALF) begin
                    if (idx == IDX_W'(s)) res_d[s] = data_a;
                end else begin
                    if (idx == IDX_W'(s - HALF)) res_d[s] = data_b;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) res_q[s] <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_out
        assign res_flat[s*DATA_W +: DATA_W] = res_q[s];
    end

endmodule

// File: rtl/scan_seq_ctrl.sv
`timescale 1ns/1ps
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int SLOTS      = 8,
    parameter int SEL_W      = 3,
    parameter int DATA_W     = 12,
    parameter int DLY_W      = 8,
    parameter int FIRST_HALF = 17,
    parameter int NEXT_HALF  = 12,
    localparam int LEN_W     = $clog2(SLOTS + 1),
    localparam int IDX_W     = $clog2(SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic [2:0]                cfg_mode,
    input  logic [LEN_W-1:0]          cfg_len,
    input  logic                      cfg_irq_en,
    input  logic [SLOTS*SEL_W-1:0]    cfg_sel,
    input  logic                      sw_start,
    input  logic                      sw_stop,
    input  logic                      timer_sync,
    input  logic                      pwm_reload,
    input  logic [DLY_W-1:0]          pwm_delay,
    input  logic                      eos_ack,
    output logic                      conv_strobe,
    output logic                      conv_busy,
    output logic                      conv_pair,
    output logic [SEL_W-1:0]          conv_sel_a,
    output logic [SEL_W-1:0]          conv_sel_b,
    input  logic [DATA_W-1:0]         conv_data_a,
    input  logic [DATA_W-1:0]         conv_data_b,
    output logic [SLOTS*DATA_W-1:0]   result,
    output logic                      eos_flag,
    output logic                      scan_irq,
    output logic                      overrun,
    output logic                      cfg_err
);

    localparam int HALF  = SLOTS / 2;
    localparam int CNT_W = $clog2(FIRST_HALF);

    typedef struct packed {
        phase_e             phase;
        logic               armed;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic               strobe;
        logic               eos;
        logic               irq;
        logic               ovr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    start_kind_e            kind;
    logic                   simul;
    logic [LEN_W-1:0]       nconv;
    logic                   irq_en;
    logic                   err_w;
    logic [SLOTS*SEL_W-1:0] sel_flat;
    logic                   dly_pulse;
    logic                   start_evt;
    logic                   can_start;
    logic                   go;
    logic                   res_wr;
    logic [IDX_W-1:0]       slot_b;

    scan_cfg #(.SLOTS(SLOTS), .SEL_W(SEL_W), .LEN_W(LEN_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .mode_in  (cfg_mode),
        .len_in   (cfg_len),
        .irq_en_in(cfg_irq_en),
        .sel_in   (cfg_sel),
        .kind     (kind),
        .simul    (simul),
        .nconv    (nconv),
        .irq_en   (irq_en),
        .cfg_err  (err_w),
        .sel_flat (sel_flat)
    );

    scan_sync_delay #(.DLY_W(DLY_W)) i_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .reload(pwm_reload),
        .delay (pwm_delay),
        .pulse (dly_pulse)
    );

    assign start_evt = sw_start | timer_sync | dly_pulse;
    assign can_start = !err_w && !sw_stop;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.strobe = 1'b0;
        ctl_d.irq    = 1'b0;
        res_wr       = 1'b0;
        go           = 1'b0;
        if (eos_ack) ctl_d.eos = 1'b0;

        case (ctl_q.phase)
            PH_IDLE: begin
                case (kind)
                    KIND_ONCE: go = ctl_q.armed && start_evt && can_start;
                    KIND_LOOP: go = ctl_q.armed && can_start;
                    KIND_TRIG: go = start_evt && can_start;
                    default:   go = 1'b0;
                endcase
                if (go) begin
                    ctl_d.phase  = PH_RUN;
                    ctl_d.cnt    = CNT_W'(FIRST_HALF - 1);
                    ctl_d.idx    = '0;
                    ctl_d.strobe = 1'b1;
                    if (kind == KIND_ONCE) ctl_d.armed = 1'b0;
                end
            end
            PH_RUN: begin
                if (start_evt) ctl_d.ovr = 1'b1;
                if (ctl_q.cnt == '0) begin
                    res_wr = 1'b1;
                    if (LEN_W'(ctl_q.idx) + LEN_W'(1) == nconv) begin
                        ctl_d.eos = 1'b1;
                        ctl_d.irq = irq_en && (kind != KIND_LOOP);
                        if (kind == KIND_LOOP && can_start) begin
                            // pipeline stays full: no fill on the next scan
                            ctl_d.idx    = '0;
                            ctl_d.cnt    = CNT_W'(NEXT_HALF - 1);
                            ctl_d.strobe = 1'b1;
                        end else begin
                            ctl_d.phase = PH_IDLE;
                        end
                    end else begin
                        ctl_d.idx    = ctl_q.idx + IDX_W'(1);
                        ctl_d.cnt    = CNT_W'(NEXT_HALF - 1);
                        ctl_d.strobe = 1'b1;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase

        if (cfg_wr) begin
            ctl_d.armed = 1'b1;
            ctl_d.ovr   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    scan_results #(.SLOTS(SLOTS), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_wr),
        .idx     (ctl_q.idx),
        .simul   (simul),
        .data_a  (conv_data_a),
        .data_b  (conv_data_b),
        .res_flat(result)
    );

    assign slot_b      = ctl_q.idx + IDX_W'(HALF);
    assign conv_strobe = ctl_q.strobe;
    assign conv_busy   = (ctl_q.phase == PH_RUN);
    assign conv_pair   = simul;
    assign conv_sel_a  = sel_flat[int'(ctl_q.idx)*SEL_W +: SEL_W];
    assign conv_sel_b  = simul ? sel_flat[int'(slot_b)*SEL_W +: SEL_W] : '0;
    assign eos_flag    = ctl_q.eos;
    assign scan_irq    = ctl_q.irq;
    assign overrun     = ctl_q.ovr;
    assign cfg_err     = err_w;

endmodule

// File: rtl/scan_seq_chk.sv
`timescale 1ns/1ps
module scan_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic sw_stop,
    input logic conv_strobe,
    input logic conv_busy,
    input logic eos_flag,
    input logic scan_irq,
    input logic overrun,
    input logic cfg_err
);

    p_no_start_on_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_busy) |-> $past(!cfg_err));

    p_strobe_in_scan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> conv_busy);

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |=> !conv_strobe);

    p_stop_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_busy) |-> $past(!sw_stop));

    p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !cfg_wr) |=> overrun);

    p_ovr_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !overrun);

    p_irq_with_eos_r12: assert property (@(posedge clk) disable iff (!rst_n)
        scan_irq |-> eos_flag);

    p_irq_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        scan_irq |=> !scan_irq);

endmodule

bind scan_seq_ctrl scan_seq_chk i_scan_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .sw_stop    (sw_stop),
    .conv_strobe(conv_strobe),
    .conv_busy  (conv_busy),
    .eos_flag   (eos_flag),
    .scan_irq   (scan_irq),
    .overrun    (overrun),
    .cfg_err    (cfg_err)
);

// File: tb/test_scan_seq_ctrl.sv
`timescale 1ns/1ps
module test_scan_seq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_mode = '0;
    logic [3:0]  cfg_len = '0;
    logic        cfg_irq_en = 1'b0;
    logic [23:0] cfg_sel = '0;
    logic        sw_start = 1'b0;
    logic        sw_stop = 1'b0;
    logic        timer_sync = 1'b0;
    logic        pwm_reload = 1'b0;
    logic [7:0]  pwm_delay = '0;
    logic        eos_ack = 1'b0;
    logic        conv_strobe, conv_busy, conv_pair;
    logic [2:0]  conv_sel_a, conv_sel_b;
    logic [11:0] conv_data_a, conv_data_b;
    logic [95:0] result;
    logic        eos_flag, scan_irq, overrun, cfg_err;

    logic [11:0] base = '0;
    int n_chk = 0;
    int n_fail = 0;
    int strobe_cnt = 0;
    int irq_cnt = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    // converter stub: pin number plus a base the bench moves between scans
    assign conv_data_a = base + 12'(conv_sel_a);
    assign conv_data_b = base + 12'h080 + 12'(conv_sel_b);

    scan_seq_ctrl i_scan_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_len(cfg_len),
        .cfg_irq_en(cfg_irq_en), .cfg_sel(cfg_sel), .sw_start(sw_start), .sw_stop(sw_stop),
        .timer_sync(timer_sync), .pwm_reload(pwm_reload), .pwm_delay(pwm_delay),
        .eos_ack(eos_ack), .conv_strobe(conv_strobe), .conv_busy(conv_busy),
        .conv_pair(conv_pair), .conv_sel_a(conv_sel_a), .conv_sel_b(conv_sel_b),
        .conv_data_a(conv_data_a), .conv_data_b(conv_data_b), .result(result),
        .eos_flag(eos_flag), .scan_irq(scan_irq), .overrun(overrun), .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (conv_strobe) strobe_cnt <= strobe_cnt + 1;
        if (scan_irq)    irq_cnt <= irq_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int slot(input int s);
        return int'(result[s*12 +: 12]);
    endfunction

    function automatic logic [23:0] sel_rev();
        logic [23:0] v;
        for (int s = 0; s < 8; s++) v[s*3 +: 3] = 3'(7 - s);
        return v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic configure(input logic [2:0] m, input logic [3:0] l, input logic ie,
                             input logic [23:0] sel);
        @(negedge clk);
        cfg_mode = m; cfg_len = l; cfg_irq_en = ie; cfg_sel = sel; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic ack_eos();
        @(negedge clk); eos_ack = 1'b1;
        @(negedge clk); eos_ack = 1'b0;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic pulse_timer();
        @(negedge clk); timer_sync = 1'b1;
        @(negedge clk); timer_sync = 1'b0;
    endtask

    task automatic pulse_pwm(input logic [7:0] d);
        @(negedge clk); pwm_delay = d; pwm_reload = 1'b1;
        @(negedge clk); pwm_reload = 1'b0;
    endtask

    // cycles from the start edge until eos_flag is seen
    task automatic wait_eos(output int n);
        n = 0;
        while (!eos_flag && n < 500) begin @(negedge clk); n++; end
    endtask

    task automatic wait_strobe(output int n);
        n = 0;
        while (!conv_strobe && n < 500) begin @(negedge clk); n++; end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (conv_busy && n < 500) begin @(negedge clk); n++; end
        tick(2);
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(conv_busy), 0);
        chk("R1 strobe", int'(conv_strobe), 0);
        chk("R1 eos", int'(eos_flag), 0);
        chk("R1 irq", int'(scan_irq), 0);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);
        chk("R1 results", int'(result != '0), 0);
    endtask

    task automatic t_once_seq();
        int n, sc, ic;
        base = 12'h100;
        configure(3'b000, 4'd3, 1'b1, sel_rev());
        sc = strobe_cnt; ic = irq_cnt;
        pulse_sw();
        wait_eos(n);
        chk("R5 seq len3 scan time", n, 41);
        tick(2);
        chk("R3 slot0", slot(0), 'h107);
        chk("R3 slot1", slot(1), 'h106);
        chk("R3 slot2", slot(2), 'h105);
        chk("R3 slot3 untouched", slot(3), 0);
        chk("R5 strobe count", strobe_cnt - sc, 3);
        chk("R12 irq once", irq_cnt - ic, 1);
        ack_eos();
        chk("R12 eos cleared", int'(eos_flag), 0);
        sc = strobe_cnt;
        pulse_sw();
        tick(40);
        chk("R6 start ignored after scan", strobe_cnt - sc, 0);
        chk("R6 no overrun when unarmed", int'(overrun), 0);
        chk("R6 eos stays clear", int'(eos_flag), 0);
        base = 12'h200;
        configure(3'b000, 4'd3, 1'b1, sel_rev());
        pulse_sw();
        wait_eos(n);
        tick(2);
        chk("R13 slot0 overwritten", slot(0), 'h207);
        chk("R13 slot3 kept", slot(3), 0);
        ack_eos();
    endtask

    task automatic t_len_clamp();
        int n;
        base = 12'h150;
        configure(3'b000, 4'd0, 1'b0, sel_rev());
        pulse_sw();
        wait_eos(n);
        chk("R3 len0 as one conversion", n, 17);
        tick(2);
        chk("R3 len0 slot0", slot(0), 'h157);
        chk("R3 len0 slot1 kept", slot(1), 'h206);
        ack_eos();
        base = 12'h160;
        configure(3'b000, 4'd15, 1'b0, sel_rev());
        pulse_sw();
        wait_eos(n);
        chk("R3 len15 as eight", n, 101);
        tick(2);
        chk("R3 len15 slot3", slot(3), 'h164);
        chk("R3 len15 slot7", slot(7), 'h160);
        ack_eos();
    endtask

    task automatic t_simul();
        int n;
        base = 12'h300;
        configure(3'b001, 4'd8, 1'b0, sel_rev());
        pulse_sw();
        chk("R4 pair flag", int'(conv_pair), 1);
        chk("R4 first pair side a", int'(conv_sel_a), 7);
        chk("R4 first pair side b", int'(conv_sel_b), 3);
        wait_eos(n);
        chk("R5 simul len8 scan time", n, 53);
        tick(2);
        for (int k = 0; k < 4; k++) begin
            chk("R4 low slot", slot(k), 'h300 + 7 - k);
            chk("R4 high slot", slot(k + 4), 'h380 + 3 - k);
        end
        ack_eos();
        base = 12'h400;
        configure(3'b001, 4'd3, 1'b0, sel_rev());
        pulse_sw();
        wait_eos(n);
        chk("R4 len3 two pairs", n, 29);
        tick(2);
        chk("R4 slot0", slot(0), 'h407);
        chk("R4 slot5", slot(5), 'h482);
        chk("R13 slot2 kept", slot(2), 'h305);
        chk("R13 slot6 kept", slot(6), 'h381);
        ack_eos();
    endtask

    task automatic t_cfg_err();
        logic [23:0] s;
        int sc;
        s = sel_rev();
        s[5*3 +: 3] = s[1*3 +: 3];
        configure(3'b001, 4'd4, 1'b0, s);
        tick(1);
        chk("R2 clash in used pair", int'(cfg_err), 1);
        sc = strobe_cnt;
        pulse_sw();
        tick(30);
        chk("R2 no scan on error", strobe_cnt - sc, 0);
        chk("R2 busy stays low", int'(conv_busy), 0);
        configure(3'b001, 4'd2, 1'b0, s);
        tick(1);
        chk("R2 clash in unused pair", int'(cfg_err), 0);
        configure(3'b110, 4'd2, 1'b0, sel_rev());
        tick(1);
        chk("R2 illegal mode", int'(cfg_err), 1);
        configure(3'b100, 4'd2, 1'b0, sel_rev());
        tick(1);
        chk("R2 legal triggered", int'(cfg_err), 0);
    endtask

    task automatic t_triggered();
        int n, sc, ic;
        base = 12'h500;
        configure(3'b100, 4'd2, 1'b1, sel_rev());
        ic = irq_cnt;
        pulse_timer();
        wait_eos(n);
        chk("R7 timer start scan time", n, 29);
        tick(2);
        chk("R7 slot1", slot(1), 'h506);
        ack_eos();
        pulse_sw();
        wait_eos(n);
        chk("R7 fill paid again", n, 29);
        tick(2);
        chk("R12 irq per scan", irq_cnt - ic, 2);
        ack_eos();
        sc = strobe_cnt;
        pulse_sw();
        tick(5);
        pulse_sw();
        wait_idle();
        chk("R11 overrun set", int'(overrun), 1);
        chk("R11 scan not restarted", strobe_cnt - sc, 2);
        ack_eos();
        configure(3'b100, 4'd2, 1'b1, sel_rev());
        tick(1);
        chk("R11 overrun cleared", int'(overrun), 0);
    endtask

    task automatic t_sync_delay();
        int n;
        pulse_pwm(8'd5);
        wait_strobe(n);
        chk("R10 pwm delay 5", n, 7);
        wait_idle();
        ack_eos();
        pulse_pwm(8'd0);
        wait_strobe(n);
        chk("R10 pwm delay 0", n, 2);
        wait_idle();
        ack_eos();
        pulse_sw();
        wait_strobe(n);
        chk("R10 software start", n, 0);
        wait_idle();
        ack_eos();
    endtask

    task automatic t_loop_stop();
        int n, t1, ic, sc;
        base = 12'h600;
        ic = irq_cnt;
        configure(3'b010, 4'd2, 1'b1, sel_rev());
        wait_eos(n);
        t1 = cyc;
        ack_eos();
        wait_eos(n);
        chk("R8 back-to-back scan interval", cyc - t1, 24);
        tick(2);
        chk("R8 no irq in loop", irq_cnt - ic, 0);
        chk("R8 slot0", slot(0), 'h607);
        @(negedge clk); sw_stop = 1'b1;
        wait_idle();
        sc = strobe_cnt;
        tick(60);
        chk("R9 stop holds off scans", strobe_cnt - sc, 0);
        chk("R9 idle under stop", int'(conv_busy), 0);
        configure(3'b000, 4'd1, 1'b0, sel_rev());
        @(negedge clk); sw_stop = 1'b0;
        ack_eos();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual run length 150000 cycles expected fewer");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_once_seq();
        t_len_clamp();
        t_simul();
        t_cfg_err();
        t_triggered();
        t_sync_delay();
        t_loop_stop();
        tick(5);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule